// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a bank of 32-bit configuration registers from a 3-wire serial EEPROM that is organised as 16-bit words. It starts on its own when reset is released. It reads the words one at a time, from address 0 upward. Each read is its own chip-select frame, made of a read command, a device start bit and sixteen data bits. The serial clock comes from dividing the bus clock.

Before it commits anything, the loader looks at the first register it assembled. If those 32 bits are all ones, the device is blank. If they are all zeros, no device is fitted. In either case the loader stops and leaves every register at its built-in default.

Once loading has finished, the EEPROM pins belong to software. Software drives chip select, clock and data out through a small control word, and reads the data-in pin back. The same control word can also start the whole automatic load again.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While a frame is in progress, `ee_sk` has a period of SK_DIV bus clocks (32 by default). It is low for the first half of each bit and high for the second half.
- R2: Each automatic read holds `ee_cs` high for 28 serial clock periods. During the first 11 bits, `ee_di` carries 1, 1, 0 and then the 8-bit word address, MSB first. Bits change only while `ee_sk` is low.
- R3: The bit that follows the address is the device's start bit and is discarded. The next 16 bits are captured MSB first, each one sampled at the rising edge of `ee_sk`.
- R4: Words are read at consecutive addresses starting at 0. Between two frames, `ee_cs` stays low for one full serial clock period, and `ee_sk` is never high while `ee_cs` is low.
- R5: Register k receives word 2k as bits 31:16 and word 2k+1 as bits 15:0. A full load reads 2·NUM_REGS words (34 by default).
- R6: If register 0 assembles to all ones, the load ends after word 1, and every register keeps its default value.
- R7: If register 0 assembles to all zeros, the load ends after word 1, and every register keeps its default value.
- R8: After reset, `load_done` is 0 and register k reads DEFAULT_BASE + k through `cfg_sel`/`cfg_data`.
- R9: `load_done` goes to 1 when a load completes or falls back to defaults. It stays at 1 until a reload is requested.
- R10: The control word has these bits: bit 0 is chip select, bit 1 is clock and bit 2 is data out. While loading, writes to these bits do not reach the pins. Once `load_done` is 1, the pins follow these bits. `ctl_din` shows `ee_do` one clock later.
- R11: A control write with bit 3 set restarts the load. It clears `load_done` and returns every register to its default before the words are read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: {reload, data out, clock, chip select} |
| ctl_din | output | 1 | Registered copy of `ee_do` |
| cfg_sel | input | 5 | Configuration register index |
| cfg_data | output | 32 | Selected configuration register |
| load_done | output | 1 | Load finished or defaults kept |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench connects a behavioural serial EEPROM that checks every command it receives. The bench then measures clock half-periods, frame length and the gap between frames. A loader that samples on the wrong edge, or keeps the start bit, would shift every stored word by one bit. A loader that merges the halves in the wrong order would swap the upper and lower 16 bits.

The blank and absent cases each check two things: the load ends after two frames, and the registers are left untouched. A design that committed register 0 before deciding would expose all-ones or all-zeros data. A reload issued after a full load must bring the defaults back first. Software writes made during a load must stay off the pins, and a hand-clocked read must return the device's word.

// File: rtl/eeld_pkg.sv
package eeld_pkg;
  typedef enum logic [1:0] {
    ST_START,
    ST_FRAME,
    ST_GAP,
    ST_IDLE
  } seq_state_e;

  localparam int unsigned WORD_LEN = 16;
  localparam logic [2:0]  READ_HDR = 3'b110;
endpackage

// File: rtl/eeld_sk_gen.sv
module eeld_sk_gen #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sk_hi,
  output logic rise_now,
  output logic period_end
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sk_hi      = run && (cnt_q >= CW'(HALF));
  assign rise_now   = run && (cnt_q == CW'(HALF - 1));
  assign period_end = run && (cnt_q == CW'(DIV - 1));

  // R1
  rise_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_now |=> (sk_hi || !run));

  // R1
  end_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !sk_hi);
endmodule

// File: rtl/eeld_frame_shift.sv
module eeld_frame_shift
  import eeld_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                advance,
  input  logic                sample,
  input  logic                capture,
  input  logic [AW-1:0]       addr,
  input  logic                din,
  output logic                dout,
  output logic [WORD_LEN-1:0] word
);
  localparam int unsigned CW = 3 + AW;

  logic [CW-1:0]       cmd_q, cmd_d;
  logic [WORD_LEN-1:0] word_q, word_d;

  always_comb begin
    cmd_d  = cmd_q;
    word_d = word_q;
    if (start) begin
      cmd_d = {READ_HDR, addr};
    end else if (advance) begin
      cmd_d = {cmd_q[CW-2:0], 1'b0};
    end
    if (sample && capture) begin
      word_d = {word_q[WORD_LEN-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      word_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      word_q <= word_d;
    end
  end

  assign dout = cmd_q[CW-1];
  assign word = word_q;

  // R2
  first_bit_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> dout);

  // R3
  capture_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && capture) |=> (word[0] == $past(din)));

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample && capture) |=> $stable(word));
endmodule

// File: rtl/eeld_cfg_bank.sv
module eeld_cfg_bank #(
  parameter int unsigned NREG     = 17,
  parameter logic [31:0] DEF_BASE = 32'hD0D0_0000,
  parameter int unsigned IW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restore,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  logic [31:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [31:0] DEF_VAL = DEF_BASE + 32'(g);
    logic [31:0] q, d;

    always_comb begin
      d = q;
      if (restore) begin
        d = DEF_VAL;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= DEF_VAL;
      else        q <= d;
    end

    assign regs_q[g] = q;
  end

  assign rd_data = (32'(rd_idx) < NREG) ? regs_q[rd_idx] : '0;

  // R5
  wr_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < NREG));

  // R11
  restore_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (regs_q[0] == DEF_BASE));
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eeld_pkg::*;
#(
  parameter int unsigned SK_DIV       = 32,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned NUM_REGS     = 17,
  parameter logic [31:0] DEFAULT_BASE = 32'hD0D0_0000,
  localparam int unsigned IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [3:0]       ctl_wdata,
  output logic             ctl_din,
  input  logic [IDX_W-1:0] cfg_sel,
  output logic [31:0]      cfg_data,
  output logic             load_done,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);
  localparam int unsigned CMD_LEN   = 3 + ADDR_W;
  localparam int unsigned FRAME_LEN = CMD_LEN + 1 + WORD_LEN;
  localparam int unsigned BIT_W     = $clog2(FRAME_LEN);
  localparam int unsigned LAST_WORD = 2 * NUM_REGS - 1;

  seq_state_e          state_q, state_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [ADDR_W-1:0]   word_q, word_d;
  logic [WORD_LEN-1:0] upper_q, upper_d;
  logic [2:0]          sw_q, sw_d;
  logic                din_q;

  logic                run, sk_hi, rise_now, period_end;
  logic                start_word, advance, restore, wr_en, busy, reload;
  logic [ADDR_W-1:0]   load_addr;
  logic                frame_di;
  logic [WORD_LEN-1:0] rx_word;
  logic [31:0]         full;

  assign reload = ctl_we && ctl_wdata[3];
  assign run    = (state_q == ST_FRAME) || (state_q == ST_GAP);
  assign busy   = (state_q != ST_IDLE);
  assign full   = {upper_q, rx_word};

  eeld_sk_gen #(.DIV(SK_DIV)) sk_gen_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sk_hi(sk_hi), .rise_now(rise_now), .period_end(period_end)
  );

  eeld_frame_shift #(.AW(ADDR_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .start(start_word), .advance(advance),
    .sample(rise_now && (state_q == ST_FRAME)),
    .capture(bit_q >= BIT_W'(CMD_LEN + 1)),
    .addr(load_addr), .din(ee_do), .dout(frame_di), .word(rx_word)
  );

  eeld_cfg_bank #(.NREG(NUM_REGS), .DEF_BASE(DEFAULT_BASE), .IW(IDX_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .restore(restore), .wr_en(wr_en),
    .wr_idx(IDX_W'(word_q >> 1)), .wr_data(full),
    .rd_idx(cfg_sel), .rd_data(cfg_data)
  );

  always_comb begin
    state_d    = state_q;
    bit_d      = bit_q;
    word_d     = word_q;
    upper_d    = upper_q;
    start_word = 1'b0;
    advance    = 1'b0;
    restore    = 1'b0;
    wr_en      = 1'b0;
    load_addr  = word_q;
    unique case (state_q)
      ST_START: begin
        restore    = 1'b1;
        start_word = 1'b1;
        load_addr  = '0;
        word_d     = '0;
        bit_d      = '0;
        state_d    = ST_FRAME;
      end
      ST_FRAME: begin
        if (period_end) begin
          if (bit_q == BIT_W'(FRAME_LEN - 1)) begin
            bit_d = '0;
            if (!word_q[0]) begin
              upper_d = rx_word;
              state_d = ST_GAP;
            end else if ((word_q == ADDR_W'(1)) && ((&full) || !(|full))) begin
              state_d = ST_IDLE;
            end else begin
              wr_en   = 1'b1;
              state_d = (word_q == ADDR_W'(LAST_WORD)) ? ST_IDLE : ST_GAP;
            end
          end else begin
            bit_d   = bit_q + 1'b1;
            advance = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (period_end) begin
          word_d     = word_q + 1'b1;
          load_addr  = word_q + 1'b1;
          start_word = 1'b1;
          state_d    = ST_FRAME;
        end
      end
      default: ;
    endcase
    if (reload) state_d = ST_START;
  end

  assign sw_d = ctl_we ? ctl_wdata[2:0] : sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      bit_q   <= '0;
      word_q  <= '0;
      upper_q <= '0;
      sw_q    <= '0;
      din_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      word_q  <= word_d;
      upper_q <= upper_d;
      sw_q    <= sw_d;
      din_q   <= ee_do;
    end
  end

  assign ee_cs     = busy ? (state_q == ST_FRAME)          : sw_q[0];
  assign ee_sk     = busy ? ((state_q == ST_FRAME) && sk_hi) : sw_q[1];
  assign ee_di     = busy ? ((state_q == ST_FRAME) && frame_di) : sw_q[2];
  assign load_done = !busy;
  assign ctl_din   = din_q;

  // R4
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ee_cs) |-> !ee_sk);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !reload) |=> load_done);

  // R11
  reload_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !load_done);
endmodule

// File: tb/eeprom_cfg_loader_tb_top.sv
module eeprom_cfg_loader_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] DEF_BASE = 32'hD0D0_0000;
  localparam int NREG = 17;
  // scenario table: [7:6] device mode (0 programmed, 1 blank, 2 absent), [5:0] frames expected
  localparam logic [7:0] SCEN [3] = '{ {2'd1, 6'd2}, {2'd2, 6'd2}, {2'd0, 6'd34} };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [3:0]  ctl_wdata;
  logic        ctl_din;
  logic [4:0]  cfg_sel;
  logic [31:0] cfg_data;
  logic        load_done, ee_cs, ee_sk, ee_di, ee_do;

  int checks = 0;
  int errors = 0;
  logic [1:0] mode = 2'd0;

  always #4 clk = ~clk;

  eeprom_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_din(ctl_din), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .load_done(load_done), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] pure_word(input logic [7:0] a);
    return 16'hA5C3 ^ {a, ~a};
  endfunction

  function automatic logic [15:0] dev_word(input logic [1:0] m, input logic [7:0] a);
    return (m == 2'd1) ? 16'hFFFF : pure_word(a);
  endfunction

  function automatic logic [31:0] exp_reg(input logic [1:0] m, input int k);
    if (m == 2'd0) return {pure_word(8'(2 * k)), pure_word(8'(2 * k + 1))};
    return DEF_BASE + 32'(k);
  endfunction

  // behavioural serial EEPROM
  int          m_cnt = 0;
  int          m_frames = 0;
  int          m_bad = 0;
  logic [10:0] m_cmd = '0;
  logic [15:0] m_word = '0;
  logic        m_do = 1'b1;
  logic [7:0]  m_prev = 8'hFF;

  always @(posedge ee_cs or posedge ee_sk) begin
    if (ee_sk) begin
      if (ee_cs) begin
        if (m_cnt < 11) m_cmd = {m_cmd[9:0], ee_di};
        m_cnt++;
      end
    end else begin
      m_cnt = 0;
    end
  end

  always @(negedge ee_sk) begin
    if (ee_cs) begin
      if (m_cnt == 11) begin
        if (m_cmd[10:8] != 3'b110 || !(m_cmd[7:0] == 8'h00 || m_cmd[7:0] == m_prev + 8'd1))
          m_bad++;
        m_prev = m_cmd[7:0];
        m_frames++;
        m_word = dev_word(mode, m_cmd[7:0]);
        m_do = 1'b0;
      end else if (m_cnt >= 12 && m_cnt <= 27) begin
        m_do = m_word[27 - m_cnt];
      end
    end
  end

  assign ee_do = (mode == 2'd2) ? 1'b0 : m_do;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [3:0] v);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic check_bank(input string req, input logic [1:0] m);
    for (int k = 0; k < NREG; k++) begin
      cfg_sel = 5'(k);
      #1;
      check(req, $sformatf("register %0d", k), cfg_data, exp_reg(m, k));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual=load not finished expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    time t0, t1, t2, ta, tb, tc;
    int f0, b0;
    logic [15:0] rd;
    logic [10:0] cmd;
    string req;

    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; cfg_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check("R8", "load_done after reset", 32'(load_done), 32'd0);
    check_bank("R8", 2'd1);
    f0 = m_frames; b0 = m_bad;

    // R1 serial clock shape
    @(posedge ee_cs);
    @(posedge ee_sk); t0 = $time;
    @(negedge ee_sk); t1 = $time;
    @(posedge ee_sk); t2 = $time;
    check("R1", "sk high clocks", 32'((t1 - t0) / 8), 32'd16);
    check("R1", "sk period clocks", 32'((t2 - t0) / 8), 32'd32);

    // R10 software writes ignored while loading
    ctl_write(4'b0110);
    repeat (3) @(negedge clk);
    check("R10", "cs held by loader", 32'(ee_cs), 32'd1);

    // R4 gap and R2 frame length
    @(negedge ee_cs); ta = $time;
    @(posedge ee_cs); tb = $time;
    @(negedge ee_cs); tc = $time;
    check("R4", "cs low gap clocks", 32'((tb - ta) / 8), 32'd32);
    check("R2", "frame clocks", 32'((tc - tb) / 8), 32'd896);

    wait (load_done);
    @(negedge clk);
    check("R10", "pins follow control", {29'd0, ee_di, ee_sk, ee_cs}, 32'b110);
    check("R5", "frames in full load", 32'(m_frames - f0), 32'd34);
    check("R2", "bad commands", 32'(m_bad - b0), 32'd0);
    check_bank("R5", 2'd0);
    repeat (100) @(negedge clk);
    check("R9", "done held", 32'(load_done), 32'd1);
    ctl_write(4'b0000);

    // scenario table via reload
    for (int i = 0; i < 3; i++) begin
      mode = SCEN[i][7:6];
      req = (mode == 2'd1) ? "R6" : (mode == 2'd2) ? "R7" : "R5";
      f0 = m_frames; b0 = m_bad;
      ctl_write(4'b1000);
      @(negedge clk);
      check("R11", "done cleared by reload", 32'(load_done), 32'd0);
      cfg_sel = '0;
      #1;
      check("R11", "register 0 restored", cfg_data, DEF_BASE);
      wait (load_done);
      @(negedge clk);
      check(req, "frames read", 32'(m_frames - f0), 32'(SCEN[i][5:0]));
      check("R4", "address order", 32'(m_bad - b0), 32'd0);
      check_bank(req, mode);
    end

    // R10 / R3 software bit-bang read of word 0x22
    cmd = {3'b110, 8'h22};
    ctl_write(4'b0001);
    for (int b = 10; b >= 0; b--) begin
      ctl_write({1'b0, cmd[b], 1'b0, 1'b1});
      ctl_write({1'b0, cmd[b], 1'b1, 1'b1});
    end
    ctl_write(4'b0001);
    repeat (2) @(negedge clk);
    check("R3", "device start bit", 32'(ctl_din), 32'd0);
    rd = '0;
    for (int j = 0; j < 16; j++) begin
      ctl_write(4'b0011);
      ctl_write(4'b0001);
      repeat (2) @(negedge clk);
      rd = {rd[14:0], ctl_din};
    end
    check("R10", "software read word", 32'(rd), 32'(pure_word(8'h22)));
    ctl_write(4'b0000);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule